// File: doc/BRIEF.md
# Programmable Chip-Select Generator

This block watches the bus cycles of a 68000-style processor and drives a bank of active-low chip-select lines, one for each programmable address window. Each channel holds a base address, an address mask and an attribute word. The attribute word enables the channel, marks it read-only, turns on an acknowledge generated by the block itself, and sets a wait-state count. When the address strobe falls, the block samples the address and the read/write line and picks the winning channel. It then holds that channel's select for the rest of the cycle.

If the winning channel has automatic acknowledge turned on, the block pulls the data-transfer acknowledge low after the programmed number of clocks. If it is off, the block leaves the acknowledge alone and the addressed device must answer. A write aimed at a read-only channel is refused: no select is driven and a bus-error line is pulled low for that cycle. Software programs the channels through a simple write-only port that carries a channel number, a field selector and data.

Top module: `csel_unit`

## Requirements
- R1: While reset is asserted and after it is released, every cs_n bit, dtack_n and berr_n is high (inactive).
- R2: A channel matches a cycle when its enable bit (attribute bit 0) is 1 and (addr AND mask) equals (base AND mask). A channel whose enable bit is 0 never drives its select.
- R3: When more than one enabled channel matches, only the lowest-numbered one drives its cs_n low.
- R4: A read (rw=1) to any matching channel, or a write (rw=0) to a matching channel whose read-only bit (attribute bit 1) is 0, drives that channel's cs_n low starting the clock after as_n is sampled low.
- R5: A write to a matching read-only channel leaves every cs_n high and holds dtack_n high. It drives berr_n low for as long as as_n stays low.
- R6: With automatic acknowledge on (attribute bit 2 = 1) and a wait count of N (attribute bits 5:3, N from 0 to 6), dtack_n falls exactly N clocks after cs_n falls and stays low until the cycle ends.
- R7: A programmed wait count of 7 behaves as 6.
- R8: With automatic acknowledge off, dtack_n stays high for the whole of a cycle that hits the channel.
- R9: One clock after as_n is sampled high, every cs_n bit, dtack_n and berr_n are high. At most one cs_n bit is low at any time.
- R10: The address and rw are sampled only when the strobe falls. Changes to them while as_n stays low do not alter the select.
- R11: Configuration writes with cfg_we=1 store cfg_wdata into the field of channel cfg_ch chosen by cfg_fld: 0 selects the base, 1 the mask, 2 the attribute word. Code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 4 | Channel number for the configuration write |
| cfg_fld | input | 2 | Field select: 0 base, 1 mask, 2 attribute |
| cfg_wdata | input | 24 | Configuration data |
| as_n | input | 1 | Address strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 24 | Bus address |
| cs_n | output | 16 | Chip selects, active low |
| dtack_n | output | 1 | Generated data-transfer acknowledge, active low |
| berr_n | output | 1 | Bus error for refused writes, active low |

## Verification
The hardest case to reach from the ports is the priority rule working together with the per-channel attributes. It needs two enabled windows that overlap and have different wait counts, so that a wrong winner shows up both in which select falls and in when the acknowledge arrives. The stimulus programs a narrow low-numbered window inside a wide higher-numbered one. It then runs cycles inside the overlap and in the part covered only by the wide window, and measures the acknowledge delay clock by clock. Every cycle also changes the address in the middle of the strobe, to show that only the sampled address counts.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;
  localparam int CS_WSW   = 3;
  localparam int CS_MAXWS = 6;

  typedef struct packed {
    logic [CS_WSW-1:0] ws;
    logic              aack;
    logic              ro;
    logic              en;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);

  localparam logic [1:0] FLD_BASE = 2'd0;
  localparam logic [1:0] FLD_MASK = 2'd1;
  localparam logic [1:0] FLD_ATTR = 2'd2;
endpackage

// File: rtl/csel_regs.sv
`timescale 1ns/1ps
module csel_regs
  import csel_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 24,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CHW-1:0]           cfg_ch,
  input  logic [1:0]               cfg_fld,
  input  logic [AW-1:0]            cfg_wdata,
  output logic [NCH-1:0][AW-1:0]   base,
  output logic [NCH-1:0][AW-1:0]   mask,
  output attr_t [NCH-1:0]          attr
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel_ch, en_base, en_mask, en_attr;
    assign sel_ch  = cfg_we && (cfg_ch == CHW'(i));
    assign en_base = sel_ch && (cfg_fld == FLD_BASE);
    assign en_mask = sel_ch && (cfg_fld == FLD_MASK);
    assign en_attr = sel_ch && (cfg_fld == FLD_ATTR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base[i] <= '0;
        mask[i] <= '0;
        attr[i] <= '0;
      end else begin
        if (en_base) base[i] <= cfg_wdata;
        if (en_mask) mask[i] <= cfg_wdata;
        if (en_attr) attr[i] <= attr_t'(cfg_wdata[ATTR_W-1:0]);
      end
    end
  end
endmodule

// File: rtl/csel_match.sv
`timescale 1ns/1ps
module csel_match
  import csel_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 24
) (
  input  logic [AW-1:0]            addr,
  input  logic [NCH-1:0][AW-1:0]   base,
  input  logic [NCH-1:0][AW-1:0]   mask,
  input  attr_t [NCH-1:0]          attr,
  output logic [NCH-1:0]           win_oh,
  output logic                     win_any,
  output logic                     win_ro,
  output logic                     win_aack,
  output logic [CS_WSW-1:0]        win_ws
);
  localparam logic [CS_WSW-1:0] WS_CAP = CS_WSW'(CS_MAXWS);

  logic [NCH-1:0] hit_raw;
  attr_t          win_attr;

  for (genvar i = 0; i < NCH; i++) begin : g_cmp
    assign hit_raw[i] = attr[i].en && ((addr & mask[i]) == (base[i] & mask[i]));
  end

  always_comb begin
    win_oh   = '0;
    win_any  = 1'b0;
    win_attr = '0;
    for (int i = 0; i < NCH; i++) begin
      if (hit_raw[i] && !win_any) begin
        win_oh[i] = 1'b1;
        win_any   = 1'b1;
        win_attr  = attr[i];
      end
    end
  end

  assign win_ro   = win_attr.ro;
  assign win_aack = win_attr.aack;
  assign win_ws   = (win_attr.ws > WS_CAP) ? WS_CAP : win_attr.ws;
endmodule

// File: rtl/csel_cycle.sv
`timescale 1ns/1ps
module csel_cycle
  import csel_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               as_n,
  input  logic               rw,
  input  logic [NCH-1:0]     win_oh,
  input  logic               win_any,
  input  logic               win_ro,
  input  logic               win_aack,
  input  logic [CS_WSW-1:0]  win_ws,
  output logic [NCH-1:0]     cs_n,
  output logic               dtack_n,
  output logic               berr_n
);
  logic              as_d_q, as_d_d;
  logic [NCH-1:0]    sel_q, sel_d;
  logic              err_q, err_d;
  logic              aack_q, aack_d;
  logic [CS_WSW-1:0] wcnt_q, wcnt_d;
  logic              start, blocked;

  assign start   = as_d_q && !as_n;
  assign blocked = win_any && win_ro && !rw;

  always_comb begin
    as_d_d = as_n;
    sel_d  = sel_q;
    err_d  = err_q;
    aack_d = aack_q;
    wcnt_d = wcnt_q;
    if (as_n) begin
      sel_d  = '0;
      err_d  = 1'b0;
      aack_d = 1'b0;
      wcnt_d = '0;
    end else if (start) begin
      sel_d  = blocked ? '0 : win_oh;
      err_d  = blocked;
      aack_d = win_any && win_aack && !blocked;
      wcnt_d = win_ws;
    end else if (wcnt_q != '0) begin
      wcnt_d = wcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_d_q <= 1'b1;
      sel_q  <= '0;
      err_q  <= 1'b0;
      aack_q <= 1'b0;
      wcnt_q <= '0;
    end else begin
      as_d_q <= as_d_d;
      sel_q  <= sel_d;
      err_q  <= err_d;
      aack_q <= aack_d;
      wcnt_q <= wcnt_d;
    end
  end

  assign cs_n    = ~sel_q;
  assign berr_n  = ~err_q;
  assign dtack_n = ~(aack_q && (wcnt_q == '0));
endmodule

// File: rtl/csel_unit.sv
`timescale 1ns/1ps
module csel_unit
  import csel_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 24,
  localparam int CHW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CHW-1:0]  cfg_ch,
  input  logic [1:0]      cfg_fld,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            as_n,
  input  logic            rw,
  input  logic [AW-1:0]   addr,
  output logic [NCH-1:0]  cs_n,
  output logic            dtack_n,
  output logic            berr_n
);
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  logic [NCH-1:0][AW-1:0] base, mask;
  attr_t [NCH-1:0]        attr;
  logic [NCH-1:0]         win_oh;
  logic                   win_any, win_ro, win_aack;
  logic [CS_WSW-1:0]      win_ws;

  csel_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_s), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata),
    .base(base), .mask(mask), .attr(attr)
  );

  csel_match #(.NCH(NCH), .AW(AW)) u_match (
    .addr(addr), .base(base), .mask(mask), .attr(attr),
    .win_oh(win_oh), .win_any(win_any), .win_ro(win_ro),
    .win_aack(win_aack), .win_ws(win_ws)
  );

  csel_cycle #(.NCH(NCH)) u_cycle (
    .clk(clk), .rst_n(rst_s), .as_n(as_n), .rw(rw),
    .win_oh(win_oh), .win_any(win_any), .win_ro(win_ro),
    .win_aack(win_aack), .win_ws(win_ws),
    .cs_n(cs_n), .dtack_n(dtack_n), .berr_n(berr_n)
  );
endmodule

// File: rtl/csel_chk.sv
`timescale 1ns/1ps
module csel_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           as_n,
  input logic [NCH-1:0] cs_n,
  input logic           dtack_n,
  input logic           berr_n
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n)); // R9
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> (&cs_n && dtack_n && berr_n)); // R9
  AST_BERR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !berr_n |-> (&cs_n && dtack_n)); // R5
  AST_DTACK_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> !(&cs_n)); // R6
  AST_DTACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n && !as_n) |=> !dtack_n); // R6
  AST_CS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !(&cs_n)) |=> $stable(cs_n)); // R10
endmodule

bind csel_unit csel_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n),
  .cs_n(cs_n), .dtack_n(dtack_n), .berr_n(berr_n)
);

// File: tb/csel_unit_tb.sv
`timescale 1ns/1ps
module csel_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_ch;
  logic [1:0]  cfg_fld;
  logic [23:0] cfg_wdata;
  logic        as_n, rw;
  logic [23:0] addr;
  logic [15:0] cs_n;
  logic        dtack_n, berr_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  csel_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_fld(cfg_fld), .cfg_wdata(cfg_wdata), .as_n(as_n), .rw(rw),
    .addr(addr), .cs_n(cs_n), .dtack_n(dtack_n), .berr_n(berr_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [23:0] mk_attr(bit en, bit ro, bit aack, int ws);
    return 24'(int'(en) | (int'(ro) << 1) | (int'(aack) << 2) | ((ws & 7) << 3));
  endfunction

  task automatic cfg(input int ch, input logic [1:0] fld, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_fld = fld; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_ch(input int ch, input logic [23:0] b, input logic [23:0] m,
                        input logic [23:0] a);
    cfg(ch, 2'd0, b);
    cfg(ch, 2'd1, m);
    cfg(ch, 2'd2, a);
  endtask

  // exp_ch < 0: no select; exp_lat < 0: no acknowledge
  task automatic bus_cycle(input string tag, input logic [23:0] a, input bit r,
                           input int exp_ch, input bit exp_err, input int exp_lat);
    logic [15:0] exp_cs;
    int lat;
    exp_cs = '1;
    if (exp_ch >= 0) exp_cs[exp_ch] = 1'b0;
    lat = -1;
    @(negedge clk);
    addr = a; rw = r; as_n = 1'b0;
    @(negedge clk);
    check({tag, " R4 select"}, 32'(cs_n), 32'(exp_cs));
    check({tag, " R5 berr"}, 32'(berr_n), 32'(!exp_err));
    for (int k = 0; k < 9; k++) begin
      if (k == 1) begin addr = 24'hF0F0F0; rw = ~r; end
      if (!dtack_n && lat < 0) lat = k;
      if (k < 8) @(negedge clk);
    end
    check({tag, " R10 select held"}, 32'(cs_n), 32'(exp_cs));
    check({tag, " R6 ack latency"}, 32'(lat), 32'(exp_lat));
    as_n = 1'b1; rw = 1'b1;
    @(negedge clk);
    check({tag, " R9 release"}, 32'({cs_n, dtack_n, berr_n}), 32'(18'h3FFFF));
  endtask

  task automatic t_reset();
    check("R1 reset cs", 32'(cs_n), 32'hFFFF);
    check("R1 reset ack/berr", 32'({dtack_n, berr_n}), 32'h3);
  endtask

  task automatic t_setup();
    set_ch(2,  24'h100000, 24'hFF0000, mk_attr(1, 0, 1, 0));
    set_ch(5,  24'h100000, 24'hF00000, mk_attr(1, 0, 1, 3));
    set_ch(7,  24'h200000, 24'hF00000, mk_attr(1, 1, 1, 6));
    set_ch(9,  24'h300000, 24'hF00000, mk_attr(1, 0, 0, 2));
    set_ch(11, 24'h400000, 24'hF00000, mk_attr(1, 0, 1, 7));
    set_ch(12, 24'h500000, 24'hF00000, mk_attr(0, 0, 1, 0));
  endtask

  task automatic t_match();
    bus_cycle("R2 ch2 read", 24'h10ABCD, 1'b1, 2, 1'b0, 0);
    bus_cycle("R3 overlap lowest wins", 24'h10FFFE, 1'b1, 2, 1'b0, 0);
    bus_cycle("R3 wide window only", 24'h123456, 1'b1, 5, 1'b0, 3);
    bus_cycle("R4 write rw channel", 24'h123456, 1'b0, 5, 1'b0, 3);
    bus_cycle("R2 disabled channel", 24'h500010, 1'b1, -1, 1'b0, -1);
    bus_cycle("R2 no window", 24'h600000, 1'b1, -1, 1'b0, -1);
  endtask

  task automatic t_readonly();
    bus_cycle("R4 read ro channel", 24'h200010, 1'b1, 7, 1'b0, 6);
    bus_cycle("R5 write ro channel", 24'h200010, 1'b0, -1, 1'b1, -1);
  endtask

  task automatic t_ack();
    bus_cycle("R8 no auto ack", 24'h300000, 1'b1, 9, 1'b0, -1);
    bus_cycle("R7 wait 7 as 6", 24'h4000AA, 1'b1, 11, 1'b0, 6);
    cfg(2, 2'd2, mk_attr(1, 0, 1, 1));
    bus_cycle("R6 wait 1", 24'h100002, 1'b1, 2, 1'b0, 1);
    cfg(2, 2'd2, mk_attr(1, 0, 1, 5));
    bus_cycle("R6 wait 5", 24'h100002, 1'b0, 2, 1'b0, 5);
  endtask

  task automatic t_cfg_ignore();
    cfg(9, 2'd3, 24'h000000);
    bus_cycle("R11 field code 3 ignored", 24'h300000, 1'b1, 9, 1'b0, -1);
    cfg(12, 2'd2, mk_attr(1, 0, 1, 2));
    bus_cycle("R11 enable via attr", 24'h500010, 1'b1, 12, 1'b0, 2);
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_fld = '0; cfg_wdata = '0;
    as_n = 1'b1; rw = 1'b1; addr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_setup();
    t_match();
    t_readonly();
    t_ack();
    t_cfg_ignore();
    finish_run();
  end
endmodule